// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer Counter

This block is a 16-bit timer counter that a CPU with an 8-bit data bus reads and writes as two byte locations, one for each half of the count, plus a flag location. Any access to the upper-half location reaches only a shared staging byte, never the counter itself. Reading the lower half copies the live upper half into that staging byte in the same cycle. Writing the lower half loads all sixteen bits in one edge, with the staging byte as the upper half. Software therefore writes upper then lower, and reads lower then upper, and always sees one coherent 16-bit value.

The counter moves on a tick chosen by a 3-bit select. Code 0 means no tick. Codes 1 to 7 pick one of seven tick-enable inputs that come from prescalers or an external pin outside this block. On each tick a mode input makes the counter count up, count down or clear. A separate clear input zeroes the count. A CPU write of the lower half overrides both the clear input and the tick. The block flags the all-ones value (TOP) and zero (BOTTOM). It also keeps a sticky overflow flag that sets when an up-count wraps from all ones to zero.

Top module: `byte_timer16`

## Requirements
- R1: After reset the count is 0x0000, the staging byte is 0x00, the overflow flag is 0, at_bottom is 1 and at_top is 0.
- R2: A write to address 1 loads only the staging byte and leaves the count unchanged. A read of address 1 returns the staging byte.
- R3: A read of address 0 returns count[7:0] combinationally and at the clock edge copies count[15:8] into the staging byte. A later read of address 1 returns that copied value, even if the counter has advanced since.
- R4: A write to address 0 loads the count with {staging byte, written byte} at a single clock edge.
- R5: On a tick, mode 2'b00 adds one, mode 2'b01 subtracts one (0x0000 wraps to 0xFFFF), and modes 2'b10 and 2'b11 clear the count.
- R6: clk_sel 0 stops the counter whatever tick_src holds, while bus access still works. clk_sel k in 1..7 uses tick_src[k-1] as the tick, and every other tick_src bit has no effect.
- R7: A write to address 0 takes priority over an active clr and an active tick in the same cycle.
- R8: With no write to address 0, clr high zeroes the count at the next edge, whether or not a tick is present.
- R9: at_top is 1 exactly when the count is 0xFFFF, and at_bottom is 1 exactly when the count is 0x0000.
- R10: The overflow flag sets when a tick in mode 2'b00 takes the count from 0xFFFF to 0x0000. It does not set on a down-count wrap. A read of address 2 returns {7'b0, flag}. Writing a byte with bit 0 set to address 2 clears the flag, and writing bit 0 as 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Byte address: 0 count low, 1 staging byte, 2 flag, 3 reads zero |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when bus_rd is low |
| clk_sel | input | 3 | Tick select, 0 stops the counter |
| tick_src | input | 7 | Precomputed tick enables for select codes 1..7 |
| mode | input | 2 | 00 up, 01 down, 1x clear on tick |
| clr | input | 1 | Synchronous counter clear |
| cnt_out | output | 16 | Current count |
| at_top | output | 1 | Count equals 0xFFFF |
| at_bottom | output | 1 | Count equals 0x0000 |
| ovf_flag | output | 1 | Sticky up-count wrap flag |

## Verification
The bench checks the staging-byte corners. It shows that an upper-half read stays stale after the counter moves past a lower-half read, which a design reading the live upper half would fail. It also shows that an upper-half write leaves the count untouched, which a design writing straight through would fail. It drives a lower-half write together with clr and a tick, so a design with the wrong priority ends up at zero or one count off. It selects a tick source while pulsing a different one, and uses select 0 with every source active, to expose select decoding that is off by one. It also takes the counter through the all-ones wrap in both directions and writes 0 to the flag, which catches an overflow flag set on down wraps or cleared by any write.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_CLR  = 2'b10
  } cnt_mode_e;

  localparam logic [ADDR_W-1:0] ADR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd2;
endpackage

// File: rtl/tmr16_rst_sync.sv
module tmr16_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/tmr16_tick_sel.sv
module tmr16_tick_sel #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N_SRC = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] src,
  output logic             tick
);
  logic [N_SRC:0] padded;

  // Code 0 maps to a constant-zero slot, so the timer stops.
  assign padded[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    assign padded[g+1] = src[g];
  end

  assign tick = padded[sel];

  always_comb begin
    assert_stopped_R6: assert (!(sel == '0 && tick));
  end
endmodule

// File: rtl/tmr16_bus_if.sv
module tmr16_bus_if
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              flag_clr
);
  logic [BYTE_W-1:0] tmp_q, tmp_d;
  logic              wr_hi, rd_lo;

  assign wr_hi    = wr && (addr == ADR_HI);
  assign rd_lo    = rd && (addr == ADR_LO);
  assign load     = wr && (addr == ADR_LO);
  assign flag_clr = wr && (addr == ADR_FLAG) && wdata[0];
  assign load_val = {tmp_q, wdata};

  always_comb begin
    tmp_d = tmp_q;
    if (wr_hi)      tmp_d = wdata;
    else if (rd_lo) tmp_d = cnt[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) tmp_q <= '0;
    else         tmp_q <= tmp_d;
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        ADR_LO:   rdata = cnt[BYTE_W-1:0];
        ADR_HI:   rdata = tmp_q;
        ADR_FLAG: rdata = {{(BYTE_W-1){1'b0}}, ovf};
        default:  rdata = '0;
      endcase
    end
  end

  assert_latch_hi_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_lo && !wr_hi) |=> tmp_q == $past(cnt[CNT_W-1:BYTE_W]));
  assert_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_hi |=> tmp_q == $past(wdata));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic             at_top,
  output logic             at_bottom
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d, wrap_up;

  always_comb begin
    cnt_d   = cnt_q;
    wrap_up = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      case (mode)
        MODE_UP: begin
          cnt_d   = cnt_q + 1'b1;
          wrap_up = (cnt_q == MAX_VAL);
        end
        MODE_DOWN: cnt_d = cnt_q - 1'b1;
        default:   cnt_d = '0;
      endcase
    end
  end

  always_comb begin
    ovf_d = ovf_q;
    if (flag_clr) ovf_d = 1'b0;
    if (wrap_up)  ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign at_top    = (cnt_q == MAX_VAL);
  assign at_bottom = (cnt_q == '0);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> cnt_q == $past(load_val));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr && !load) |=> cnt_q == '0);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick && !clr && !load) |=> $stable(cnt_q));
  assert_ovf_src_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovf_q) |-> ($past(cnt_q) == MAX_VAL && $past(mode) == MODE_UP && $past(tick)));
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import tmr16_pkg::*;
#(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N_SRC = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [N_SRC-1:0]  tick_src,
  input  logic [1:0]        mode,
  input  logic              clr,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              at_top,
  output logic              at_bottom,
  output logic              ovf_flag
);
  logic             rst_ni, tick, load, flag_clr;
  logic [CNT_W-1:0] load_val;

  tmr16_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  tmr16_tick_sel #(.SEL_W(SEL_W)) i_sel (
    .sel(clk_sel), .src(tick_src), .tick(tick)
  );

  tmr16_bus_if i_bus (
    .clk(clk), .rst_ni(rst_ni), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt_out), .ovf(ovf_flag),
    .load(load), .load_val(load_val), .flag_clr(flag_clr)
  );

  tmr16_core i_core (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .mode(mode), .clr(clr),
    .load(load), .load_val(load_val), .flag_clr(flag_clr),
    .cnt_q(cnt_out), .ovf_q(ovf_flag), .at_top(at_top), .at_bottom(at_bottom)
  );

  assert_load_beats_clr_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && bus_addr == ADR_LO && clr) |=> cnt_out[BYTE_W-1:0] == $past(bus_wdata));
endmodule

// File: tb/test_byte_timer16.sv
module test_byte_timer16;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [2:0]  clk_sel;
  logic [6:0]  tick_src;
  logic [1:0]  mode;
  logic        clr;
  logic [15:0] cnt_out;
  logic        at_top, at_bottom, ovf_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  byte_timer16 i_byte_timer16 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_sel(clk_sel), .tick_src(tick_src), .mode(mode), .clr(clr),
    .cnt_out(cnt_out), .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  // start, mode, sel, src mask, cycles, expected
  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {16'h0010, 2'b00, 3'd1, 7'b0000001, 8'd5, 16'h0015},
    {16'h0010, 2'b01, 3'd1, 7'b0000001, 8'd5, 16'h000B},
    {16'h1234, 2'b10, 3'd3, 7'b0000100, 8'd1, 16'h0000},
    {16'h0100, 2'b00, 3'd3, 7'b1111011, 8'd4, 16'h0100},
    {16'h0100, 2'b00, 3'd0, 7'b1111111, 8'd4, 16'h0100},
    {16'h00FF, 2'b00, 3'd7, 7'b1000000, 8'd2, 16'h0101},
    {16'h0000, 2'b01, 3'd2, 7'b0000010, 8'd1, 16'hFFFF},
    {16'hFFFE, 2'b11, 3'd5, 7'b0010000, 8'd1, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic load16(input logic [15:0] v);
    bus_write(2'd1, v[15:8]);
    bus_write(2'd0, v[7:0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] rb;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    clk_sel = '0; tick_src = '0; mode = 2'b00; clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 count", cnt_out, 16'h0000);
    chk("R1 ovf", {15'd0, ovf_flag}, 16'd0);
    chk("R1 bottom", {15'd0, at_bottom}, 16'd1);
    chk("R1 top", {15'd0, at_top}, 16'd0);
    bus_read(2'd1, rb);
    chk("R1 staging", {8'd0, rb}, 16'h0000);

    // R5 R6 table of vectors
    for (int i = 0; i < NV; i++) begin
      logic [15:0] st, ex;
      logic [7:0]  n;
      st = VEC[i][51:36]; ex = VEC[i][15:0]; n = VEC[i][23:16];
      tick_src = '0;
      load16(st);
      @(negedge clk);
      mode = VEC[i][35:34]; clk_sel = VEC[i][33:31]; tick_src = VEC[i][30:24];
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick_src = '0;
      chk($sformatf("R5/R6 vector %0d count", i), cnt_out, ex);
      bus_read(2'd0, rb);
      chk($sformatf("R3 vector %0d low read", i), {8'd0, rb}, {8'd0, ex[7:0]});
      bus_read(2'd1, rb);
      chk($sformatf("R3 vector %0d high read", i), {8'd0, rb}, {8'd0, ex[15:8]});
    end

    // R3 stale high after counter advances
    mode = 2'b00; clk_sel = 3'd1;
    load16(16'h12FE);
    bus_read(2'd0, rb);
    chk("R3 low", {8'd0, rb}, 16'h00FE);
    @(negedge clk); tick_src = 7'b0000001;
    repeat (3) @(posedge clk);
    @(negedge clk); tick_src = '0;
    chk("R5 advanced", cnt_out, 16'h1301);
    bus_read(2'd1, rb);
    chk("R3 stale high", {8'd0, rb}, 16'h0012);

    // R2 high write does not touch count
    bus_write(2'd1, 8'hAB);
    chk("R2 count kept", cnt_out, 16'h1301);
    bus_read(2'd1, rb);
    chk("R2 staging read", {8'd0, rb}, 16'h00AB);

    // R4 R7 low write beats clr and tick
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h05; bus_wr = 1; clr = 1; tick_src = 7'h7F;
    @(negedge clk);
    bus_wr = 0; clr = 0; tick_src = '0;
    chk("R7/R4 write priority", cnt_out, 16'hAB05);

    // R8 clr with tick
    @(negedge clk); clr = 1; tick_src = 7'h7F;
    @(negedge clk); clr = 0; tick_src = '0;
    chk("R8 clear", cnt_out, 16'h0000);
    chk("R9 bottom at zero", {15'd0, at_bottom}, 16'd1);

    // R9 R10 up wrap
    load16(16'hFFFF);
    chk("R9 top", {15'd0, at_top}, 16'd1);
    chk("R9 not bottom", {15'd0, at_bottom}, 16'd0);
    chk("R10 no flag yet", {15'd0, ovf_flag}, 16'd0);
    @(negedge clk); mode = 2'b00; clk_sel = 3'd1; tick_src = 7'b0000001;
    @(negedge clk); tick_src = '0;
    chk("R10 wrap count", cnt_out, 16'h0000);
    bus_read(2'd2, rb);
    chk("R10 flag set", {8'd0, rb}, 16'h0001);
    bus_write(2'd2, 8'hFE);
    chk("R10 write 0 keeps flag", {15'd0, ovf_flag}, 16'd1);
    bus_write(2'd2, 8'h01);
    chk("R10 write 1 clears", {15'd0, ovf_flag}, 16'd0);

    // R10 down wrap does not set flag
    @(negedge clk); mode = 2'b01; tick_src = 7'b0000001;
    @(negedge clk); tick_src = '0;
    chk("R5 down wrap", cnt_out, 16'hFFFF);
    chk("R10 down wrap no flag", {15'd0, ovf_flag}, 16'd0);

    finish_run();
  end
endmodule